// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block forms the word address for each beat of a four-beat burst on a synchronous memory. A load cycle captures a full external address and starts a burst; later advance cycles step only the two lowest address bits, while every bit above them stays as loaded. The order of the steps is set by a strap: linear order counts the low bits up by one with wrap-around, and interleaved order XORs the starting low bits with a beat count.

One shared control pin picks load or advance. An active-low clock enable gates every register, so holding it high stretches the current cycle. A load that does not request an access acts as a deselect. It ends the burst, and after it only a fresh load can start a new one. Chip-select decoding, the storage array and the data path are outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears its state: after that edge `burst_active` is 0 and `addr_out` is all zeros.
- R2: A rising edge with `clk_en_n` low, `adv_nload` low and `start_req` high captures `addr_in`. After that edge `addr_out` equals that address and `burst_active` is 1.
- R3: A rising edge with `clk_en_n` low, `adv_nload` low and `start_req` low is a deselect. It drives `burst_active` to 0 and leaves `addr_out` unchanged.
- R4: With `order_ilv` = 0, each advance edge (`clk_en_n` low, `adv_nload` high, burst active) sets `addr_out[1:0]` to its previous value plus one, modulo 4.
- R5: With `order_ilv` = 1, after k advance edges since the load, `addr_out[1:0]` equals the loaded low bits XOR (k mod 4).
- R6: Advance edges never change `addr_out` bits above bit 1.
- R7: While `clk_en_n` is high at a rising edge (and `rst_n` is high), `addr_out` and `burst_active` hold whatever the other inputs do.
- R8: An advance edge while `burst_active` is 0 is ignored: `burst_active` stays 0 and `addr_out` is unchanged.
- R9: After four advance edges in either order, the low bits return to the loaded low bits and the burst stays active.
- R10: Reset takes effect even while `clk_en_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high holds all state |
| adv_nload | input | 1 | 1 = advance the burst, 0 = load or deselect |
| start_req | input | 1 | On a load cycle: 1 starts a burst, 0 deselects |
| order_ilv | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External address, sampled on load cycles |
| addr_out | output | ADDR_W | Current access address |
| burst_active | output | 1 | High while a burst is in progress |

## Verification
The assertions take the order strap as steady across an advance edge. The linear-step property only checks edges where `order_ilv` does not change across the edge. All other properties assume only that the inputs are driven, with known values, once reset has been released. The stimulus changes inputs only on the falling clock edge and changes the strap only between bursts. It still drives deliberately out-of-protocol patterns, such as advances with no burst in progress and toggling load inputs while the clock enable is high, so that the ignore and hold rules are exercised.

// File: rtl/burst_seq_pkg.sv
// Package: shared types for the burst address generator.
// Assumes: a single clock domain; all consumers import this package.
package burst_seq_pkg;

    // Per-edge action decoded from the control pins.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,  // no state change
        ACT_START = 2'd1,  // capture address, begin burst
        ACT_STOP  = 2'd2,  // deselect, end burst
        ACT_STEP  = 2'd3   // advance the beat counter
    } burst_act_e;

endpackage

// File: rtl/burst_ctrl.sv
// Module: burst_ctrl
// Decodes clock enable, load/advance and start request into one action per edge.
// Assumes: inputs are synchronous to the clock; reset is handled by the registers.
module burst_ctrl
    import burst_seq_pkg::*;
(
    input  logic       clk_en_n,
    input  logic       adv_nload,
    input  logic       start_req,
    input  logic       active,
    output burst_act_e action
);

    // Priority: clock enable gates everything, then load beats advance.
    always_comb begin
        if (clk_en_n) begin
            action = ACT_HOLD;
        end else if (!adv_nload) begin
            action = start_req ? ACT_START : ACT_STOP;
        end else if (active) begin
            action = ACT_STEP;
        end else begin
            action = ACT_HOLD;
        end
    end

endmodule

// File: rtl/burst_addr_reg.sv
// Module: burst_addr_reg
// Holds the address captured at the start of a burst.
// Assumes: only ACT_START changes the stored address; reset clears it.
module burst_addr_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  burst_act_e        action,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_addr
);

    // Capture the external address on a start; otherwise keep it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
        end else if (action == ACT_START) begin
            base_addr <= addr_in;
        end
    end

    // R6: the base changes only on a start edge.
    assert_base_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (action != ACT_START) |=> $stable(base_addr));

endmodule

// File: rtl/burst_step_cnt.sv
// Module: burst_step_cnt
// Counts beats since the last load and tracks whether a burst is active.
// Assumes: the count wraps naturally at 2**CNT_W beats.
module burst_step_cnt
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  burst_act_e       action,
    output logic [CNT_W-1:0] step,
    output logic             active
);

    // Update beat count and active flag according to the decoded action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step   <= '0;
            active <= 1'b0;
        end else begin
            case (action)
                ACT_START: begin
                    step   <= '0;
                    active <= 1'b1;
                end
                ACT_STOP:  active <= 1'b0;
                ACT_STEP:  step   <= step + 1'b1;
                default:   ;
            endcase
        end
    end

    // R8: with no burst, a hold leaves the flag low.
    assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && action == ACT_HOLD) |=> (!active && $stable(step)));

    // R3: a deselect drops the active flag.
    assert_stop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ACT_STOP) |=> !active);

endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps starting low bits and beat count to the current low address bits.
// Assumes: the order strap is static within a burst.
module burst_order_map #(
    parameter int CNT_W = 2
) (
    input  logic             interleave,
    input  logic [CNT_W-1:0] start_lo,
    input  logic [CNT_W-1:0] step,
    output logic [CNT_W-1:0] lo_out
);

    logic [CNT_W-1:0] lin_lo;
    logic [CNT_W-1:0] ilv_lo;

    // Linear order: modular add of the beat count.
    always_comb lin_lo = start_lo + step;

    // Interleaved order: bitwise XOR, one bit per generated slice.
    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        assign ilv_lo[b] = start_lo[b] ^ step[b];
    end

    // Select the order picked by the strap.
    always_comb lo_out = interleave ? ilv_lo : lin_lo;

endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Generates the per-beat address of a four-beat burst, linear or interleaved.
// Assumes: ADDR_W > CNT_W; synchronous active-low reset overrides clock enable.
module burst_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              adv_nload,
    input  logic              start_req,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_active
);

    localparam int CNT_W = 2;
    localparam int HI_W  = ADDR_W - CNT_W;

    burst_act_e        action;
    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  step;
    logic [CNT_W-1:0]  lo_bits;

    burst_ctrl u_ctrl (
        .clk_en_n  (clk_en_n),
        .adv_nload (adv_nload),
        .start_req (start_req),
        .active    (burst_active),
        .action    (action)
    );

    burst_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
        .clk       (clk),
        .rst_n     (rst_n),
        .action    (action),
        .addr_in   (addr_in),
        .base_addr (base_addr)
    );

    burst_step_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .action (action),
        .step   (step),
        .active (burst_active)
    );

    burst_order_map #(.CNT_W(CNT_W)) u_map (
        .interleave (order_ilv),
        .start_lo   (base_addr[CNT_W-1:0]),
        .step       (step),
        .lo_out     (lo_bits)
    );

    // Join fixed upper bits with the sequenced low bits.
    always_comb addr_out = {base_addr[ADDR_W-1:CNT_W], lo_bits};

    // R2: a start edge presents the captured address next cycle.
    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_nload && start_req)
        |=> (burst_active && addr_out == $past(addr_in)));

    // R7: a masked clock holds the outputs.
    assert_ce_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(addr_out) && $stable(burst_active)
                      || !$stable(order_ilv)));

    // R6: an advance keeps the upper address bits.
    assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_nload)
        |=> (addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W])));

    // R4: a linear advance adds one to the low bits.
    assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_nload && burst_active && !order_ilv)
        |=> (order_ilv || addr_out[CNT_W-1:0] == $past(addr_out[CNT_W-1:0]) + 1'b1));

    // R8: an advance with no burst is ignored.
    assert_idle_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_nload && !burst_active)
        |=> (!burst_active && ($stable(addr_out) || !$stable(order_ilv))));

    // R1, R10: reset clears outputs even with the clock masked.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!burst_active && addr_out == '0));

    initial assert (HI_W > 0) else $error("ADDR_W must exceed the counter width");

endmodule

// File: tb/burst_addr_gen_tb_top.sv
// Scoreboard bench: the driver pushes model predictions, the monitor compares.
module burst_addr_gen_tb_top;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n, clk_en_n, adv_nload, start_req, order_ilv;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic          burst_active;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [AW-1:0] addr;
        logic          act;
        string         req;
    } exp_t;

    exp_t sb_q[$];

    // Reference model state.
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_step = '0;
    logic          m_act  = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    burst_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en_n     (clk_en_n),
        .adv_nload    (adv_nload),
        .start_req    (start_req),
        .order_ilv    (order_ilv),
        .addr_in      (addr_in),
        .addr_out     (addr_out),
        .burst_active (burst_active)
    );

    // Drive one cycle, update the model and push the predicted result.
    task automatic drive(input logic r, input logic ce, input logic adv,
                         input logic st, input logic [AW-1:0] a,
                         input logic m, input string req);
        exp_t e;
        logic [1:0] lo;
        @(negedge clk);
        rst_n = r; clk_en_n = ce; adv_nload = adv;
        start_req = st; addr_in = a; order_ilv = m;
        if (!r) begin
            m_base = '0; m_step = '0; m_act = 1'b0;
        end else if (!ce) begin
            if (!adv) begin
                if (st) begin m_base = a; m_step = '0; m_act = 1'b1; end
                else m_act = 1'b0;
            end else if (m_act) begin
                m_step = m_step + 2'd1;
            end
        end
        lo = m ? (m_base[1:0] ^ m_step) : (m_base[1:0] + m_step);
        e.addr = {m_base[AW-1:2], lo};
        e.act  = m_act;
        e.req  = req;
        sb_q.push_back(e);
        @(posedge clk);
    endtask

    // Monitor: compare just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (addr_out !== e.addr || burst_active !== e.act) begin
                    errors++;
                    $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b",
                             e.req, addr_out, burst_active, e.addr, e.act);
                end
            end
        end
    end

    // Stimulus.
    initial begin
        rst_n = 1'b0; clk_en_n = 1'b1; adv_nload = 1'b0;
        start_req = 1'b0; order_ilv = 1'b0; addr_in = '0;
        drive(0, 0, 0, 0, '0, 0, "R1");
        drive(0, 1, 1, 1, 18'h3FFFF, 0, "R1");
        // R8: advance with no burst
        drive(1, 0, 1, 0, 18'h155AA, 0, "R8");
        drive(1, 0, 1, 1, 18'h0F0F3, 0, "R8");
        // R2, R4, R9, R6: linear from every start
        for (int s = 0; s < 4; s++) begin
            drive(1, 0, 0, 1, {16'hA5C3, 2'(s)}, 0, "R2");
            for (int k = 0; k < 4; k++)
                drive(1, 0, 1, 0, 18'h3FFFF, 0, k == 3 ? "R9" : "R4_R6");
        end
        // R5, R9: interleaved from every start
        for (int s = 0; s < 4; s++) begin
            drive(1, 0, 0, 1, {16'h5A3C, 2'(s)}, 1, "R2");
            for (int k = 0; k < 4; k++)
                drive(1, 0, 1, 0, '0, 1, k == 3 ? "R9" : "R5_R6");
        end
        // R7: clock masked mid-burst, other inputs toggling
        drive(1, 0, 0, 1, 18'h2D2D1, 1, "R2");
        drive(1, 0, 1, 0, '0, 1, "R5");
        drive(1, 1, 0, 1, 18'h11112, 1, "R7");
        drive(1, 1, 0, 0, 18'h22223, 1, "R7");
        drive(1, 1, 1, 0, 18'h33330, 1, "R7");
        drive(1, 0, 1, 0, '0, 1, "R5");
        // R3: deselect, then R8 ignored advance
        drive(1, 0, 0, 0, 18'h0ABCD, 1, "R3");
        drive(1, 0, 1, 0, 18'h0ABCD, 1, "R8");
        drive(1, 0, 1, 0, 18'h0ABCD, 1, "R8");
        // R10: reset with clock masked, mid-burst
        drive(1, 0, 0, 1, 18'h3C3C2, 0, "R2");
        drive(1, 0, 1, 0, '0, 0, "R4");
        drive(0, 1, 1, 0, '0, 0, "R10");
        drive(1, 0, 1, 0, '0, 0, "R8");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule